// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface and walks the attached device through its mandatory start-up sequence before any normal traffic is allowed. After a synchronous reset it holds the clock enable low for a programmable stable-clock wait. It then raises clock enable and issues NOPs. After that it issues a fixed series of commands: precharge-all, the three extended mode register writes (the first extended register last, with its DLL enable bit forced on), a mode register write that resets the DLL, a 200-clock DLL settle window, a second precharge-all, two auto-refreshes, and a final mode register write with the DLL reset bit cleared.

The sequencer also spaces the commands. Consecutive commands are separated by a programmable mode-register delay, and refreshes by the programmable refresh cycle time. Once the final mode write has been spaced out, the block raises a sticky completion flag. The values written into the mode registers come from configuration inputs. The block itself fixes only the bits that the ordering rules depend on. While it runs, every cycle that carries no command is driven as a NOP.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low, and on the first clock after it, `cke` is 0, the command is NOP, and `init_done` is 0. After reset is released, `cke` first reads 1 exactly T_WAIT+1 clock edges later. A reset asserted in the middle of the sequence returns all of these outputs to this state on the next edge.
- R2: Exactly nine non-NOP commands are issued with `cke` high, in this order: precharge-all, write EMR2, write EMR3, write EMR1, write MR (DLL reset), precharge-all, refresh, refresh, write MR (final). No other command is ever issued.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, precharge=0010, refresh=0001 and mode write=0000. A precharge-all drives address bit 10 high.
- R4: A mode write selects its register on the bank pins: MR=0, EMR1=1, EMR2=2, EMR3=3. Its opcode is placed on address bits 12..0 and all higher address bits are 0. EMR2 and EMR3 carry their configuration values unchanged.
- R5: The EMR1 write carries its configuration value with address bit 0 forced to 0, which enables the DLL.
- R6: The first MR write carries its configuration value with address bit 8 forced to 1 (DLL reset). The final MR write carries its configuration value with bit 8 forced to 0.
- R7: The first precharge-all comes T_MRD cycles after `cke` rises. Each later command follows the one before it by T_MRD cycles, except for the gaps given in R8 and R9.
- R8: After the DLL-reset MR write, exactly T_DLL cycles pass, with NOP only, before the next command.
- R9: The second refresh follows the first by T_RFC cycles, and the final MR write follows the second refresh by T_RFC cycles.
- R10: `init_done` rises exactly T_MRD cycles after the final MR write. It then stays high with only NOP on the command pins until reset.
- R11: No extended mode write is issued before a precharge-all, and no MR write is issued before the EMR1 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| mr_val | input | MODE_W | Opcode for the mode register (bit 8 overridden) |
| emr1_val | input | MODE_W | Opcode for extended register 1 (bit 0 overridden) |
| emr2_val | input | MODE_W | Opcode for extended register 2 |
| emr3_val | input | MODE_W | Opcode for extended register 3 |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank / mode-register select |
| addr | output | ADDR_W | Address / opcode bus |
| init_done | output | 1 | Sticky flag: device ready for normal traffic |

## Verification
The hardest situation to reach from the ports is a reset that lands partway through the sequence, inside the long DLL settle window. There the step state and the cycle counter are both busy and must both be discarded. The bench counts clock edges from reset release, drops reset at a cycle it computes to fall inside that window, and checks the outputs on the next edge. The full sequence is then replayed under several opcode patterns (all zeros, all ones and two alternating patterns), so that every forced bit is seen to override an input value of both polarities.

// File: rtl/ddr2_init_pkg.sv
// Package: shared step/command types and encodings for the DDR2 init sequencer.
// Assumes a 13-bit mode opcode and the standard DDR2 command pin truth table.
package ddr2_init_pkg;

    // Sequence steps in issue order; ST_WAIT holds clock enable low.
    typedef enum logic [3:0] {
        ST_WAIT,
        ST_CKE,
        ST_PALL1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1,
        ST_MRS_DLL,
        ST_PALL2,
        ST_REF1,
        ST_REF2,
        ST_MRS_FIN,
        ST_DONE
    } step_e;

    // Command kind issued on the first cycle of a step.
    typedef enum logic [1:0] {
        OP_NOP,
        OP_PALL,
        OP_REF,
        OP_MRW
    } op_e;

    // {cs_n, ras_n, cas_n, we_n} encodings.
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PALL = 4'b0010;
    localparam logic [3:0] CMD_REF  = 4'b0001;
    localparam logic [3:0] CMD_MRW  = 4'b0000;

    // Bit positions the device decodes.
    localparam int PALL_BIT    = 10;
    localparam int DLL_EN_BIT  = 0;
    localparam int DLL_RST_BIT = 8;

    // Which command a step issues.
    function automatic op_e step_op(input step_e s);
        case (s)
            ST_PALL1, ST_PALL2:                          return OP_PALL;
            ST_REF1, ST_REF2:                            return OP_REF;
            ST_EMR2, ST_EMR3, ST_EMR1,
            ST_MRS_DLL, ST_MRS_FIN:                      return OP_MRW;
            default:                                     return OP_NOP;
        endcase
    endfunction

    // Successor step; ST_DONE is terminal.
    function automatic step_e step_next(input step_e s);
        case (s)
            ST_WAIT:    return ST_CKE;
            ST_CKE:     return ST_PALL1;
            ST_PALL1:   return ST_EMR2;
            ST_EMR2:    return ST_EMR3;
            ST_EMR3:    return ST_EMR1;
            ST_EMR1:    return ST_MRS_DLL;
            ST_MRS_DLL: return ST_PALL2;
            ST_PALL2:   return ST_REF1;
            ST_REF1:    return ST_REF2;
            ST_REF2:    return ST_MRS_FIN;
            default:    return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
// Module: down-counting dwell timer.
// Loads a value when told to and otherwise counts down to zero and holds.
// Assumes load_val and rst_val fit in CNT_W bits.
module ddr2_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rst_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload, decrement, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= rst_val;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag for the step controller.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/ddr2_init_step.sv
// Module: step controller for the init sequence.
// Holds each step for its dwell time and flags the first cycle of a new step.
// Assumes all timing parameters are at least 1.
module ddr2_init_step
    import ddr2_init_pkg::*;
#(
    parameter int T_WAIT = 100,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 26,
    parameter int T_DLL  = 200
) (
    input  logic  clk,
    input  logic  rst_n,
    output step_e step,
    output logic  fresh
);

    localparam int MAX_A = (T_WAIT > T_MRD) ? T_WAIT : T_MRD;
    localparam int MAX_B = (T_RFC > T_DLL) ? T_RFC : T_DLL;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);

    step_e            step_q;
    step_e            step_nx;
    logic             fresh_q;
    logic             expired;
    logic [CNT_W-1:0] dwell_m1;

    // Successor step and its dwell time minus one.
    always_comb begin
        step_nx = step_next(step_q);
        case (step_nx)
            ST_MRS_DLL:       dwell_m1 = CNT_W'(T_DLL - 1);
            ST_REF1, ST_REF2: dwell_m1 = CNT_W'(T_RFC - 1);
            ST_DONE:          dwell_m1 = '0;
            default:          dwell_m1 = CNT_W'(T_MRD - 1);
        endcase
    end

    ddr2_init_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_val  (CNT_W'(T_WAIT - 1)),
        .load     (expired),
        .load_val (dwell_m1),
        .expired  (expired)
    );

    // Step register: advance when the dwell timer runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_WAIT;
            fresh_q <= 1'b0;
        end else begin
            fresh_q <= expired && (step_q != ST_DONE);
            if (expired) begin
                step_q <= step_nx;
            end
        end
    end

    assign step  = step_q;
    assign fresh = fresh_q;

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
// Module: command/address encoder with registered pin outputs.
// Drives one command on the first cycle of a command step and NOP otherwise.
// Assumes ADDR_W > PALL_BIT and ADDR_W >= MODE_W, BANK_W >= 2.
module ddr2_init_cmd_enc
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic              fresh,
    input  logic [MODE_W-1:0] mr_val,
    input  logic [MODE_W-1:0] emr1_val,
    input  logic [MODE_W-1:0] emr2_val,
    input  logic [MODE_W-1:0] emr3_val,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    op_e               op;
    logic [3:0]        cmd_d;
    logic [BANK_W-1:0] ba_d;
    logic [ADDR_W-1:0] addr_d;
    logic [MODE_W-1:0] opc;

    // Command kind for this cycle.
    always_comb begin
        op = fresh ? step_op(step) : OP_NOP;
        case (op)
            OP_PALL: cmd_d = CMD_PALL;
            OP_REF:  cmd_d = CMD_REF;
            OP_MRW:  cmd_d = CMD_MRW;
            default: cmd_d = CMD_NOP;
        endcase
    end

    // Mode opcode with the sequence-mandated bits forced.
    always_comb begin
        opc = '0;
        case (step)
            ST_EMR2:    opc = emr2_val;
            ST_EMR3:    opc = emr3_val;
            ST_EMR1: begin
                opc             = emr1_val;
                opc[DLL_EN_BIT] = 1'b0;
            end
            ST_MRS_DLL: begin
                opc              = mr_val;
                opc[DLL_RST_BIT] = 1'b1;
            end
            ST_MRS_FIN: begin
                opc              = mr_val;
                opc[DLL_RST_BIT] = 1'b0;
            end
            default:    opc = '0;
        endcase
    end

    // Bank select and address bus for this cycle.
    always_comb begin
        ba_d   = '0;
        addr_d = '0;
        if (op == OP_PALL) begin
            addr_d[PALL_BIT] = 1'b1;
        end else if (op == OP_MRW) begin
            addr_d[MODE_W-1:0] = opc;
            case (step)
                ST_EMR1: ba_d = BANK_W'(1);
                ST_EMR2: ba_d = BANK_W'(2);
                ST_EMR3: ba_d = BANK_W'(3);
                default: ba_d = '0;
            endcase
        end
    end

    // Output registers toward the device pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke       <= 1'b0;
            cmd       <= CMD_NOP;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
        end else begin
            cke       <= (step != ST_WAIT);
            cmd       <= cmd_d;
            ba        <= ba_d;
            addr      <= addr_d;
            init_done <= (step == ST_DONE);
        end
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// Module: top of the DDR2 power-up initialization sequencer.
// Ties the step controller to the pin encoder. Every timing parameter is in
// controller clock cycles and must be at least 1.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int T_WAIT = 100,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 26,
    parameter int T_DLL  = 200,
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mr_val,
    input  logic [MODE_W-1:0] emr1_val,
    input  logic [MODE_W-1:0] emr2_val,
    input  logic [MODE_W-1:0] emr3_val,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    step_e      step;
    logic       fresh;
    logic [3:0] cmd;

    ddr2_init_step #(
        .T_WAIT (T_WAIT),
        .T_MRD  (T_MRD),
        .T_RFC  (T_RFC),
        .T_DLL  (T_DLL)
    ) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .fresh (fresh)
    );

    ddr2_init_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .MODE_W (MODE_W)
    ) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .fresh     (fresh),
        .mr_val    (mr_val),
        .emr1_val  (emr1_val),
        .emr2_val  (emr2_val),
        .emr3_val  (emr3_val),
        .cke       (cke),
        .cmd       (cmd),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

    // Split the packed command onto the control pins.
    assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Module: assertion checker bound to the sequencer top.
// Watches the pins only. It keeps its own gap counters, so the spacing
// windows need no parameter-sized $past or delay.
module ddr2_init_seq_chk #(
    parameter int T_MRD  = 2,
    parameter int T_DLL  = 200,
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    logic [3:0]  cmd;
    logic        is_cmd;
    logic        is_mrw;
    logic [15:0] gap_cnt;
    logic [15:0] dll_cnt;
    logic        seen_cmd;
    logic        seen_dll;
    logic        seen_pall;
    logic        seen_emr1;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd = cke && (cmd != 4'b0111);
    assign is_mrw = is_cmd && (cmd == 4'b0000);

    // Track distances since the last command and since the DLL-reset write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt   <= '1;
            dll_cnt   <= '1;
            seen_cmd  <= 1'b0;
            seen_dll  <= 1'b0;
            seen_pall <= 1'b0;
            seen_emr1 <= 1'b0;
        end else begin
            gap_cnt  <= is_cmd ? 16'd1 : ((gap_cnt == '1) ? gap_cnt : gap_cnt + 1'b1);
            seen_cmd <= seen_cmd || is_cmd;
            if (is_mrw && ba == '0 && addr[8]) begin
                dll_cnt  <= 16'd1;
                seen_dll <= 1'b1;
            end else if (dll_cnt != '1) begin
                dll_cnt <= dll_cnt + 1'b1;
            end
            if (is_cmd && cmd == 4'b0010) seen_pall <= 1'b1;
            if (is_mrw && ba == BANK_W'(1)) seen_emr1 <= 1'b1;
        end
    end

    // R3: only the four legal encodings appear on the pins
    a_r3_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0111 || cmd == 4'b0010 || cmd == 4'b0001 || cmd == 4'b0000);

    // R1: while clock enable is low, only NOP and no completion
    a_r1_cke_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == 4'b0111 && !init_done));

    // R7: commands are never closer than the mode-register delay
    a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && seen_cmd) |-> (gap_cnt >= 16'(T_MRD)));

    // R8: nothing but NOP inside the DLL settle window
    a_r8_dll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && seen_dll) |-> (dll_cnt >= 16'(T_DLL)));

    // R5: EMR1 always enables the DLL
    a_r5_dll_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrw && ba == BANK_W'(1)) |-> !addr[0]);

    // R3: precharge-all drives address bit 10
    a_r3_pall_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && cmd == 4'b0010) |-> addr[10]);

    // R11: extended writes follow a precharge-all; MR writes follow EMR1
    a_r11_emr_after_pall: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrw && ba != '0) |-> seen_pall);
    a_r11_mr_after_emr1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrw && ba == '0) |-> seen_emr1);

    // R10: completion is sticky and quiet
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    a_r10_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && cmd == 4'b0111));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .T_MRD  (T_MRD),
    .T_DLL  (T_DLL),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/ddr2_init_seq_bench.sv
// Bench: replays the whole sequence under several opcode patterns and one
// mid-sequence reset. Expected times and values are computed from the
// requirements.
module ddr2_init_seq_bench;

    localparam int T_WAIT = 5;
    localparam int T_MRD  = 3;
    localparam int T_RFC  = 9;
    localparam int T_DLL  = 200;
    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;
    localparam int MODE_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MODE_W-1:0] mr_val = '0;
    logic [MODE_W-1:0] emr1_val = '0;
    logic [MODE_W-1:0] emr2_val = '0;
    logic [MODE_W-1:0] emr3_val = '0;
    logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BANK_W-1:0] ba;
    logic [ADDR_W-1:0] addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ddr2_init_seq #(
        .T_WAIT (T_WAIT), .T_MRD (T_MRD), .T_RFC (T_RFC), .T_DLL (T_DLL),
        .ADDR_W (ADDR_W), .BANK_W (BANK_W), .MODE_W (MODE_W)
    ) u_ddr2_init_seq (
        .clk (clk), .rst_n (rst_n),
        .mr_val (mr_val), .emr1_val (emr1_val), .emr2_val (emr2_val), .emr3_val (emr3_val),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected command time of each event, counted in edges after release.
    function automatic int exp_time(input int i);
        int t = T_WAIT + 1 + T_MRD;
        for (int j = 0; j < i; j++) begin
            if (j == 4)               t += T_DLL;
            else if (j == 6 || j == 7) t += T_RFC;
            else                       t += T_MRD;
        end
        return t;
    endfunction

    function automatic logic [3:0] exp_cmd(input int i);
        if (i == 0 || i == 5) return 4'b0010;
        if (i == 6 || i == 7) return 4'b0001;
        return 4'b0000;
    endfunction

    task automatic check_reset_state(input string req);
        chk(cke == 1'b0, req, int'(cke), 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(init_done == 1'b0, req, int'(init_done), 0);
    endtask

    task automatic run_seq(input logic [12:0] m, input logic [12:0] e1,
                           input logic [12:0] e2, input logic [12:0] e3);
        logic [3:0]  ev_cmd  [16];
        logic [2:0]  ev_ba   [16];
        logic [13:0] ev_addr [16];
        int          ev_t    [16];
        int n_ev = 0, cke_rise = -1, done_t = -1, drops = 0;
        int t_done = exp_time(8) + T_MRD;
        mr_val = m; emr1_val = e1; emr2_val = e2; emr3_val = e3;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("R1 reset");
        rst_n = 1'b1;
        for (int k = 1; k <= t_done + 20; k++) begin
            @(negedge clk);
            if (k == 1) check_reset_state("R1 first edge");
            if (cke && cke_rise < 0) cke_rise = k;
            if (cke && {cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (n_ev < 16) begin
                    ev_cmd[n_ev]  = {cs_n, ras_n, cas_n, we_n};
                    ev_ba[n_ev]   = ba;
                    ev_addr[n_ev] = addr;
                    ev_t[n_ev]    = k;
                end
                n_ev++;
            end
            if (init_done && done_t < 0) done_t = k;
            if (done_t >= 0 && !init_done) drops++;
        end
        chk(cke_rise == T_WAIT + 1, "R1 cke rise", cke_rise, T_WAIT + 1);
        chk(n_ev == 9, "R2 command count", n_ev, 9);
        for (int i = 0; i < 9 && i < n_ev; i++) begin
            logic [13:0] ea;
            logic [2:0]  eb;
            chk(ev_cmd[i] == exp_cmd(i), "R2/R3 command kind", int'(ev_cmd[i]), int'(exp_cmd(i)));
            if (i == 4) chk(ev_t[i] + T_DLL == exp_time(5), "R8 dll window", ev_t[i], exp_time(4));
            else if (i == 7 || i == 8) chk(ev_t[i] == exp_time(i), "R9 refresh gap", ev_t[i], exp_time(i));
            else chk(ev_t[i] == exp_time(i), "R7 command gap", ev_t[i], exp_time(i));
            ea = '0; eb = '0;
            case (i)
                1: begin eb = 3'd2; ea = {1'b0, e2}; end
                2: begin eb = 3'd3; ea = {1'b0, e3}; end
                3: begin eb = 3'd1; ea = {1'b0, e1 & ~13'h001}; end
                4: begin eb = 3'd0; ea = {1'b0, m | 13'h100}; end
                8: begin eb = 3'd0; ea = {1'b0, m & ~13'h100}; end
                default: ;
            endcase
            if (i == 0 || i == 5) chk(ev_addr[i][10] == 1'b1, "R3 precharge-all bit", int'(ev_addr[i][10]), 1);
            else if (i == 3) chk(ev_ba[i] == eb && ev_addr[i] == ea, "R5 emr1 dll enable", int'(ev_addr[i]), int'(ea));
            else if (i == 4 || i == 8) chk(ev_ba[i] == eb && ev_addr[i] == ea, "R6 mr dll reset bit", int'(ev_addr[i]), int'(ea));
            else if (i == 1 || i == 2) chk(ev_ba[i] == eb && ev_addr[i] == ea, "R4 ext write", int'(ev_addr[i]), int'(ea));
        end
        chk(n_ev == 9 && ev_t[3] < ev_t[4], "R11 emr1 before mr", n_ev, 9);
        chk(done_t == t_done, "R10 done time", done_t, t_done);
        chk(drops == 0, "R10 done sticky", drops, 0);
    endtask

    task automatic mid_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= exp_time(4) + 50; k++) @(negedge clk);
        chk(cke == 1'b1, "R1 mid-run cke before reset", int'(cke), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 mid-run reset");
    endtask

    initial begin
        run_seq(13'h0000, 13'h0000, 13'h0000, 13'h0000);
        run_seq(13'h1FFF, 13'h1FFF, 13'h1FFF, 13'h1FFF);
        run_seq(13'h1555, 13'h0AAA, 13'h1555, 13'h0AAA);
        run_seq(13'h0AAA, 13'h1555, 13'h0AAA, 13'h1555);
        mid_reset();
        run_seq(13'h0432, 13'h0044, 13'h0008, 13'h0000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule